// File: doc/BRIEF.md
# Keyed Truth-Table Gate Node

This block is one logic-gate cell of a circuit emulator in which gates exchange values as key/payload packets instead of over wires. Its configuration sets a run length in ticks, the two keys that identify its inputs, the key it stamps on its own output, and a four-bit truth table. Any two-input boolean function can be selected through the truth table.

The node watches a stream of incoming packets. When a packet's key equals an input key, the node keeps the least significant payload bit as that input's current value; every other packet leaves it unchanged. On each tick strobe the node looks up the truth table with the values it held before that tick and sends one packet carrying its output key and the result bit. The output uses a valid/ready handshake. A change therefore moves through one gate per tick. Once the configured number of ticks has elapsed, the node stays silent until it is configured again.

The control is a four-state machine. ST_IDLE is the state after reset, before any configuration; ticks are ignored there. A configuration write moves any state to ST_RUN, the armed state with no packet pending. In ST_RUN, a tick within the run length emits a packet and moves to ST_HOLD, while a tick past the run length moves to ST_DONE. In ST_HOLD a packet is waiting. Acceptance without a tick returns the machine to ST_RUN. A tick within the run length stays in ST_HOLD: the slot is refilled if the waiting packet is accepted in the same cycle, and otherwise the new result is dropped and overflow is raised. A tick past the run length moves to ST_DONE once the waiting packet is accepted. ST_DONE ignores ticks.

Top module: `lut_gate_node`

## Requirements
- R1: After reset, out_valid and overflow are 0, both held inputs are 0, and ticks received before the first configuration write produce no packet.
- R2: The result is truth-table bit {b,a}: a=0,b=0 gives bit 0; a=1,b=0 gives bit 1; a=0,b=1 gives bit 2; a=1,b=1 gives bit 3. The result is placed in payload bit 0 and all higher payload bits are 0. The table 4'b1110 acts as OR, 4'b1000 as AND, and 4'b0110 as XOR.
- R3: A packet with in_valid high and a key equal to the A key stores payload bit 0 as input a. A key equal to the B key stores it as input b. A packet with any other key changes neither input.
- R4: For each of the first cfg_sim_len ticks after a configuration write, exactly one packet with out_key equal to the configured output key is offered. out_valid rises in the cycle after the tick.
- R5: A tick uses the inputs held before its own cycle. An input packet arriving in the same cycle as a tick affects only later ticks.
- R6: Ticks past cfg_sim_len (tick count starting at 1) emit nothing. With cfg_sim_len=0, no packet is ever emitted.
- R7: While out_valid is high and out_ready is low, out_valid, out_key and out_payload hold their values.
- R8: A tick within the run length that arrives while a packet is pending and not being accepted keeps the pending packet, drops the new result, and sets overflow, which then stays set. If the pending packet is accepted in the tick's cycle, the new packet takes its place.
- R9: When the A and B keys are equal, one matching packet updates both inputs.
- R10: A configuration write loads all settings, restarts the tick count, and clears both the pending packet and overflow from the next cycle. The held inputs are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sim_len | input | TICK_W | Number of ticks that emit |
| cfg_key_a | input | KEY_W | Key selecting input a |
| cfg_key_b | input | KEY_W | Key selecting input b |
| cfg_key_out | input | KEY_W | Key stamped on emitted packets |
| cfg_table | input | 4 | Truth table, index {b,a} |
| in_valid | input | 1 | Incoming packet present |
| in_key | input | KEY_W | Incoming packet key |
| in_payload | input | PAY_W | Incoming payload, bit 0 used |
| tick | input | 1 | Evaluation strobe |
| out_valid | output | 1 | Output packet offered |
| out_ready | input | 1 | Output packet accepted when high with out_valid |
| out_key | output | KEY_W | Output packet key |
| out_payload | output | PAY_W | Output payload, result in bit 0 |
| overflow | output | 1 | Sticky flag for a dropped result |

## Verification
The bench builds the node with KEY_W=8, PAY_W=4 and TICK_W=6. Narrow keys make it easy to pick matching, foreign and output-key packets. A four-bit payload shows that the upper payload bits are ignored on input and zero on output. With a six-bit tick counter, short run lengths such as 0, 4, 10 and 20 can be driven past their end within a few hundred cycles. Together these settings bring the stop condition, backpressure with overflow, and reconfiguration during a pending packet within easy reach.

// File: rtl/lut_gate_pkg.sv
`timescale 1ns/1ps
package lut_gate_pkg;
    localparam int NUM_INPUTS = 2;
    localparam int TABLE_W    = 1 << NUM_INPUTS;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2,
        ST_DONE = 2'd3
    } node_state_e;
endpackage

// File: rtl/lut_input_latch.sv
`timescale 1ns/1ps
module lut_input_latch #(
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pkt_valid,
    input  logic [KEY_W-1:0] pkt_key,
    input  logic             pkt_bit,
    input  logic [KEY_W-1:0] match_key,
    output logic             value
);
    logic hit;
    assign hit = pkt_valid && (pkt_key == match_key);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= 1'b0;
        end else if (hit) begin
            value <= pkt_bit;
        end
    end

    // R3: a matching packet is captured
    p_latch_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_key == match_key) |=> (value == $past(pkt_bit)));

    // R3: anything else leaves the stored value alone
    p_latch_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(pkt_valid && pkt_key == match_key) |=> $stable(value));
endmodule

// File: rtl/lut_tick_ctrl.sv
`timescale 1ns/1ps
module lut_tick_ctrl
    import lut_gate_pkg::*;
#(
    parameter int TICK_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [TICK_W-1:0] cfg_sim_len,
    input  logic              tick,
    input  logic              out_ready,
    output logic              emit,
    output logic              drop,
    output logic              pending
);
    node_state_e       state_q, state_d;
    logic [TICK_W-1:0] len_q;
    logic [TICK_W-1:0] cnt_q;
    logic              cnt_inc;
    logic              more_left;

    assign more_left = (cnt_q < len_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // run length and tick counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= '0;
            cnt_q <= '0;
        end else if (cfg_we) begin
            len_q <= cfg_sim_len;
            cnt_q <= '0;
        end else if (cnt_inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        emit    = 1'b0;
        drop    = 1'b0;
        cnt_inc = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_IDLE;
            end
            ST_RUN: begin
                if (tick && more_left) begin
                    emit    = 1'b1;
                    cnt_inc = 1'b1;
                    state_d = ST_HOLD;
                end else if (tick) begin
                    state_d = ST_DONE;
                end
            end
            ST_HOLD: begin
                if (tick && more_left) begin
                    cnt_inc = 1'b1;
                    if (out_ready) begin
                        emit = 1'b1;
                    end else begin
                        drop = 1'b1;
                    end
                end else if (tick) begin
                    if (out_ready) begin
                        state_d = ST_DONE;
                    end
                end else if (out_ready) begin
                    state_d = ST_RUN;
                end
            end
            ST_DONE: begin
                state_d = ST_DONE;
            end
        endcase
        if (cfg_we) begin
            state_d = ST_RUN;
            emit    = 1'b0;
            drop    = 1'b0;
            cnt_inc = 1'b0;
        end
    end

    assign pending = (state_q == ST_HOLD);

    // R6: a finished node stays finished until reconfigured
    p_done_stays_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !cfg_we) |=> (state_q == ST_DONE));

    // R6: the counter never passes the run length
    p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> (cnt_q <= len_q));

    // R1: no emission before the first configuration
    p_idle_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> !pending);
endmodule

// File: rtl/lut_out_stage.sv
`timescale 1ns/1ps
module lut_out_stage #(
    parameter int KEY_W = 32,
    parameter int PAY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             drop,
    input  logic [KEY_W-1:0] load_key,
    input  logic             load_bit,
    output logic [KEY_W-1:0] pkt_key,
    output logic [PAY_W-1:0] pkt_payload,
    output logic             overflow
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pkt_key     <= '0;
            pkt_payload <= '0;
        end else if (load) begin
            pkt_key     <= load_key;
            pkt_payload <= {{(PAY_W-1){1'b0}}, load_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            overflow <= 1'b0;
        end else if (clear) begin
            overflow <= 1'b0;
        end else if (drop) begin
            overflow <= 1'b1;
        end
    end

    // R8: overflow is sticky
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);
endmodule

// File: rtl/lut_gate_node.sv
`timescale 1ns/1ps
module lut_gate_node
    import lut_gate_pkg::*;
#(
    parameter int KEY_W  = 32,
    parameter int PAY_W  = 32,
    parameter int TICK_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [TICK_W-1:0]  cfg_sim_len,
    input  logic [KEY_W-1:0]   cfg_key_a,
    input  logic [KEY_W-1:0]   cfg_key_b,
    input  logic [KEY_W-1:0]   cfg_key_out,
    input  logic [TABLE_W-1:0] cfg_table,
    input  logic               in_valid,
    input  logic [KEY_W-1:0]   in_key,
    input  logic [PAY_W-1:0]   in_payload,
    input  logic               tick,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [KEY_W-1:0]   out_key,
    output logic [PAY_W-1:0]   out_payload,
    output logic               overflow
);
    logic [KEY_W-1:0]      in_keys [NUM_INPUTS];
    logic [KEY_W-1:0]      key_out_q;
    logic [TABLE_W-1:0]    table_q;
    logic [NUM_INPUTS-1:0] held;
    logic                  result;
    logic                  emit;
    logic                  drop;
    logic                  pay_unused;

    assign pay_unused = ^in_payload[PAY_W-1:1];

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_keys[0] <= '0;
            in_keys[1] <= '0;
            key_out_q  <= '0;
            table_q    <= '0;
        end else if (cfg_we) begin
            in_keys[0] <= cfg_key_a;
            in_keys[1] <= cfg_key_b;
            key_out_q  <= cfg_key_out;
            table_q    <= cfg_table;
        end
    end

    // one keyed latch per gate input; index 0 is a, index 1 is b
    for (genvar g = 0; g < NUM_INPUTS; g++) begin : g_input
        lut_input_latch #(.KEY_W(KEY_W)) u_latch (
            .clk       (clk),
            .rst_n     (rst_n),
            .pkt_valid (in_valid),
            .pkt_key   (in_key),
            .pkt_bit   (in_payload[0]),
            .match_key (in_keys[g]),
            .value     (held[g])
        );
    end

    assign result = table_q[held];

    lut_tick_ctrl #(.TICK_W(TICK_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sim_len (cfg_sim_len),
        .tick        (tick),
        .out_ready   (out_ready),
        .emit        (emit),
        .drop        (drop),
        .pending     (out_valid)
    );

    lut_out_stage #(.KEY_W(KEY_W), .PAY_W(PAY_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (cfg_we),
        .load        (emit),
        .drop        (drop),
        .load_key    (key_out_q),
        .load_bit    (result),
        .pkt_key     (out_key),
        .pkt_payload (out_payload),
        .overflow    (overflow)
    );

    // R7: an offered packet holds while not accepted
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !cfg_we) |=>
            (out_valid && $stable(out_key) && $stable(out_payload)));

    // R10: configuration clears pending packet and overflow
    p_cfg_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (!out_valid && !overflow));

    // R8: overflow only rises from a tick against a stalled packet
    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(out_valid && !out_ready && tick));

    // R4: a new offer always follows a tick
    p_emit_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(tick));

    // R2: upper payload bits of an offered packet are zero
    p_payload_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_payload >> 1) == '0);
endmodule

// File: tb/lut_gate_node_test.sv
`timescale 1ns/1ps
module lut_gate_node_test;
    localparam int KW = 8;
    localparam int PW = 4;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [TW-1:0] cfg_sim_len = '0;
    logic [KW-1:0] cfg_key_a = '0, cfg_key_b = '0, cfg_key_out = '0;
    logic [3:0]    cfg_table = '0;
    logic          in_valid = 1'b0;
    logic [KW-1:0] in_key = '0;
    logic [PW-1:0] in_payload = '0;
    logic          tick = 1'b0;
    logic          out_ready = 1'b1;
    logic          out_valid;
    logic [KW-1:0] out_key;
    logic [PW-1:0] out_payload;
    logic          overflow;

    int    checks = 0;
    int    errors = 0;
    int    accepted = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    lut_gate_node #(.KEY_W(KW), .PAY_W(PW), .TICK_W(TW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sim_len(cfg_sim_len),
        .cfg_key_a(cfg_key_a), .cfg_key_b(cfg_key_b), .cfg_key_out(cfg_key_out),
        .cfg_table(cfg_table), .in_valid(in_valid), .in_key(in_key),
        .in_payload(in_payload), .tick(tick), .out_valid(out_valid),
        .out_ready(out_ready), .out_key(out_key), .out_payload(out_payload),
        .overflow(overflow)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_a, m_b, m_live, m_done, m_cnt, m_valid, m_key, m_pay, m_ovf;
    int m_len, m_ka, m_kb, m_ko, m_tbl;
    always @(posedge clk) begin
        int acc, res, na, nb;
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_live = 0; m_done = 0; m_cnt = 0;
            m_valid = 0; m_key = 0; m_pay = 0; m_ovf = 0;
            m_len = 0; m_ka = 0; m_kb = 0; m_ko = 0; m_tbl = 0;
        end else begin
            acc = (m_valid != 0 && out_ready) ? 1 : 0;
            res = (m_tbl >> (m_a + 2 * m_b)) & 1;
            na = m_a; nb = m_b;
            if (in_valid) begin
                if (int'(in_key) == m_ka) na = in_payload[0];
                if (int'(in_key) == m_kb) nb = in_payload[0];
            end
            if (cfg_we) begin
                m_len = cfg_sim_len; m_ka = cfg_key_a; m_kb = cfg_key_b;
                m_ko = cfg_key_out; m_tbl = cfg_table;
                m_cnt = 0; m_valid = 0; m_ovf = 0; m_live = 1; m_done = 0;
            end else if (tick && m_live != 0 && m_done == 0) begin
                if (m_cnt < m_len) begin
                    m_cnt++;
                    if (m_valid == 0 || acc != 0) begin
                        m_valid = 1; m_key = m_ko; m_pay = res;
                    end else begin
                        m_ovf = 1;
                    end
                end else if (m_valid == 0 || acc != 0) begin
                    m_valid = 0; m_done = 1;
                end
            end else if (acc != 0) begin
                m_valid = 0;
            end
            m_a = na; m_b = nb;
        end
    end

    always @(posedge clk) if (rst_n && out_valid && out_ready) accepted++;

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cur_req, "out_valid", out_valid, m_valid);
            if (m_valid != 0) begin
                chk(cur_req, "out_key", out_key, m_key);
                chk(cur_req, "out_payload", out_payload, m_pay);
            end
            chk(cur_req, "overflow", overflow, m_ovf);
        end
    end

    task automatic step(input bit v, input int k, input int p, input bit t);
        in_valid = v; in_key = k[KW-1:0]; in_payload = p[PW-1:0]; tick = t;
        @(posedge clk); #2;
        in_valid = 1'b0; tick = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0);
    endtask

    task automatic configure(input int len, input int ka, input int kb, input int ko, input int tbl);
        cfg_we = 1'b1; cfg_sim_len = len[TW-1:0]; cfg_key_a = ka[KW-1:0];
        cfg_key_b = kb[KW-1:0]; cfg_key_out = ko[KW-1:0]; cfg_table = tbl[3:0];
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic tick_and_check(input string req, input int exp_bit);
        step(0, 0, 0, 1);
        chk(req, "tick valid", out_valid, 1);
        chk(req, "tick payload", out_payload, exp_bit);
    endtask

    initial begin
        int base;
        repeat (3) @(posedge clk);
        #2;
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset overflow", overflow, 0);
        rst_n = 1'b1;
        idle(1);
        // R1: ticks before configuration
        step(0, 0, 0, 1); step(0, 0, 0, 1); idle(1);
        chk("R1", "no packet before config", out_valid, 0);
        chk("R1", "accepted before config", accepted, 0);

        // R2 / R4: OR gate, run length 10
        cur_req = "R2";
        configure(10, 1, 2, 4, 4'b1110);
        base = accepted;
        for (int c = 0; c < 4; c++) begin
            step(1, 1, c & 1, 0);
            step(1, 2, (c >> 1) | 4'he, 0);
            tick_and_check("R2", ((c & 1) | (c >> 1)));
            chk("R4", "output key", out_key, 4);
            idle(2);
        end
        // R5: same-cycle input does not affect this tick (a=1,b=1 held)
        cur_req = "R5";
        step(1, 1, 0, 1);
        chk("R5", "same cycle a", out_payload, 1);
        step(1, 2, 0, 1);
        chk("R5", "same cycle b", out_payload, 1);
        tick_and_check("R5", 0);
        idle(1);
        // R3: foreign key and output key are ignored
        cur_req = "R3";
        step(1, 7, 1, 0);
        step(1, 4, 1, 0);
        tick_and_check("R3", 0);
        idle(1);
        // R6: ticks 9 and 10 emit, 11 and 12 do not
        cur_req = "R6";
        step(0, 0, 0, 1); idle(1);
        step(0, 0, 0, 1); idle(1);
        step(0, 0, 0, 1); idle(1);
        chk("R6", "past run length", out_valid, 0);
        step(0, 0, 0, 1); idle(1);
        chk("R6", "ten packets", accepted - base, 10);

        // R10 / R2: reconfigure as XOR, run length 4
        cur_req = "R10";
        configure(4, 1, 2, 6, 4'b0110);
        base = accepted;
        for (int c = 0; c < 4; c++) begin
            step(1, 1, c & 1, 0);
            step(1, 2, c >> 1, 0);
            tick_and_check("R2", ((c & 1) ^ (c >> 1)));
            chk("R10", "new output key", out_key, 6);
            idle(1);
        end
        step(0, 0, 0, 1); idle(1);
        chk("R10", "restarted count", accepted - base, 4);

        // R6: zero run length
        cur_req = "R6";
        configure(0, 1, 2, 6, 4'b1000);
        step(0, 0, 0, 1); idle(1);
        chk("R6", "zero length silent", out_valid, 0);

        // R9: shared key updates both inputs (AND)
        cur_req = "R9";
        configure(20, 5, 5, 9, 4'b1000);
        step(1, 5, 0, 0);
        tick_and_check("R9", 0);
        idle(1);
        step(1, 5, 1, 0);
        tick_and_check("R9", 1);
        idle(1);

        // R7 / R8: backpressure and overflow
        cur_req = "R7";
        out_ready = 1'b0;
        tick_and_check("R7", 1);
        idle(3);
        chk("R7", "held valid", out_valid, 1);
        chk("R7", "held payload", out_payload, 1);
        cur_req = "R8";
        step(1, 5, 0, 0);
        step(0, 0, 0, 1);
        chk("R8", "overflow set", overflow, 1);
        chk("R8", "old packet kept", out_payload, 1);
        out_ready = 1'b1;
        step(0, 0, 0, 1);
        chk("R8", "replaced valid", out_valid, 1);
        chk("R8", "replaced payload", out_payload, 0);
        chk("R8", "overflow sticky", overflow, 1);
        idle(1);
        chk("R8", "drained", out_valid, 0);

        // R10: reconfigure while pending and overflowed
        cur_req = "R10";
        out_ready = 1'b0;
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        chk("R10", "overflow before reload", overflow, 1);
        configure(3, 5, 5, 9, 4'b0001);
        chk("R10", "pending cleared", out_valid, 0);
        chk("R10", "overflow cleared", overflow, 0);
        out_ready = 1'b1;
        tick_and_check("R10", 1);
        idle(2);

        finished = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule